// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single memory-mapped timer built around a 24-bit down-counter. Software fills a load register, then writes the control register with the enable bit set. The load value goes into the counter, and the counter steps down once per prescaled tick. When it steps from 1 to 0, a level interrupt is raised. In auto-reload mode the counter refills from the load register on that same tick and keeps running, which makes a periodic event source. In one-shot mode it parks at zero.

With the maximum load and auto-reload set, the block also serves as a free-running counter. Software reads the current value and subtracts it from 0xFFFFFF to get an up-count. The interrupt stays asserted until software writes any value to the clear register.

The bus is a plain synchronous register port. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high and `bus_wr` is low. The address is a word index.

Top module: `interval_timer`

## Requirements
- R1: The load and value registers are 24 bits wide. Reads of either return zero in bits 31:24, and write data above bit 23 is discarded.
- R2: While enabled, the counter decreases by exactly one per prescaled tick. Word index 1 reads the current count.
- R3: While enable (control bit 7) is clear, the count does not change and the interrupt is never raised.
- R4: On the tick that moves the count from 1 to 0, the interrupt is raised. With auto-reload (control bit 6) clear, the count then stays at 0 while enable remains set.
- R5: With auto-reload set, the tick that would reach 0 instead reloads the count from the load register and raises the interrupt. A load of N then gives one interrupt every N ticks.
- R6: A write of any data to the clear register (word index 3) drops the interrupt on the following edge.
- R7: Control bits 3:2 select the tick rate: 00 gives one tick per clock, 01 one per 16 clocks, 10 one per 256 clocks, and 11 behaves as 00.
- R8: The load value is copied into the counter only by a control write that changes enable from 0 to 1. Other control or load writes leave the running count alone.
- R9: If a clear write lands on the same edge as an expiry, the interrupt stays set.
- R10: The prescaler restarts whenever enable is clear, so the first tick after enabling comes one full prescale period after the enabling write.
- R11: Word index 0 is load, 1 is value (writes ignored), 2 is control (reads back bits 7, 6 and 3:2, with other bits zero), and 3 is clear (reads zero).
- R12: After reset, all registers read zero and the interrupt is low. Intervals from 4 to 0xFFFFFF ticks work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt, set on expiry |

## Verification
The bench places a clear write on the exact edge of a periodic expiry. A design that let the clear win would drop the interrupt and lose an event.

It disables the timer in the middle of a prescale period and then re-enables it. A prescaler that kept its count would tick early after re-enabling.

It rewrites the control register while the timer runs. A design that reloaded on every control write would restart the count instead of continuing.

It also checks that a one-shot counter parks at zero without raising further interrupts. Finally, it times the divide-by-16, divide-by-256 and reserved encodings to the exact cycle of expiry.

// File: rtl/itmr_pkg.sv
// Shared definitions for the interval timer: register indices, control
// bit positions and the prescaler encoding. Assumes a 2-bit word index.
package itmr_pkg;

    localparam int CNT_W   = 24;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] IDX_LOAD  = 2'd0;
    localparam logic [ADDR_W-1:0] IDX_VALUE = 2'd1;
    localparam logic [ADDR_W-1:0] IDX_CTRL  = 2'd2;
    localparam logic [ADDR_W-1:0] IDX_CLEAR = 2'd3;

    localparam int BIT_EN   = 7;
    localparam int BIT_AUTO = 6;
    localparam int BIT_PS_L = 2;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV16  = 2'b01,
        PS_DIV256 = 2'b10,
        PS_RSVD   = 2'b11
    } presc_e;

    typedef struct packed {
        logic   en;
        logic   auto_rl;
        presc_e presc;
    } ctrl_t;

endpackage

// File: rtl/itmr_prescale.sv
// Tick generator. Produces a single-cycle tick every 1, 2**MID_SHIFT or
// 2**HI_SHIFT clocks depending on the select code. Assumes en is the
// registered enable. The internal count is held at zero while disabled.
module itmr_prescale
    import itmr_pkg::*;
#(
    parameter int MID_SHIFT = 4,
    parameter int HI_SHIFT  = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  presc_e presc,
    output logic   tick
);
    localparam int PRE_W = HI_SHIFT;
    localparam logic [PRE_W-1:0] LAST_MID = PRE_W'((1 << MID_SHIFT) - 1);
    localparam logic [PRE_W-1:0] LAST_HI  = PRE_W'((1 << HI_SHIFT) - 1);

    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] last;

    // Terminal count for the selected division; reserved code acts as /1.
    always_comb begin
        case (presc)
            PS_DIV16:  last = LAST_MID;
            PS_DIV256: last = LAST_HI;
            default:   last = '0;
        endcase
    end

    assign tick = en && (pcnt >= last);

    // Prescale counter: cleared while disabled and after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) pcnt <= '0;
        else                       pcnt <= pcnt + 1'b1;
    end

    // R10: no tick can come out while the timer is disabled.
    p_no_tick_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick);
    // R7: in the /16 mode two ticks never come back to back.
    p_div16_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && presc == PS_DIV16) |=> !tick);
endmodule

// File: rtl/itmr_counter.sv
// The 24-bit down-counter. Loads on the enable-rise event, steps down on
// each tick, and either refills or parks at zero when it reaches zero.
// Assumes load_evt and tick never coincide, because tick needs the old
// enable high and load_evt needs it low.
module itmr_counter
    import itmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load_evt,
    input  logic             tick,
    input  logic             auto_rl,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = tick && (cnt == ONE);

    // Count register: load, reload on expiry, park at zero, or step down.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load_evt)          cnt <= load_val;
        else if (expire)            cnt <= auto_rl ? load_val : '0;
        else if (tick && cnt != '0) cnt <= cnt - ONE;
    end

    // R3: a disabled timer keeps its count.
    p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load_evt) |=> $stable(cnt));
    // R5: expiry with auto-reload refills from the load register.
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && auto_rl) |=> cnt == $past(load_val));
    // R4: one-shot expiry parks the counter at zero.
    p_oneshot_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !auto_rl) |=> cnt == '0);
endmodule

// File: rtl/itmr_regs.sv
// Register file and interrupt flag. Decodes word-indexed writes, builds
// the enable-rise load event and serves combinational read data.
// Assumes bus_sel qualifies every access.
module itmr_regs
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              expire,
    output logic [CNT_W-1:0]  load_val,
    output ctrl_t             ctrl,
    output logic              load_evt,
    output logic              irq
);
    logic wr_load, wr_ctrl, wr_clear;

    assign wr_load  = bus_sel && bus_wr && (bus_addr == IDX_LOAD);
    assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == IDX_CTRL);
    assign wr_clear = bus_sel && bus_wr && (bus_addr == IDX_CLEAR);
    assign load_evt = wr_ctrl && bus_wdata[BIT_EN] && !ctrl.en;

    // Load register, low counter bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_val <= '0;
        else if (wr_load) load_val <= bus_wdata[CNT_W-1:0];
    end

    // Control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else if (wr_ctrl) begin
            ctrl.en      <= bus_wdata[BIT_EN];
            ctrl.auto_rl <= bus_wdata[BIT_AUTO];
            ctrl.presc   <= presc_e'(bus_wdata[BIT_PS_L +: 2]);
        end
    end

    // Interrupt flag: expiry sets and takes priority over a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (expire)   irq <= 1'b1;
        else if (wr_clear) irq <= 1'b0;
    end

    // Read data mux by word index.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                IDX_LOAD:  bus_rdata[CNT_W-1:0] = load_val;
                IDX_VALUE: bus_rdata[CNT_W-1:0] = cnt_val;
                IDX_CTRL: begin
                    bus_rdata[BIT_EN]         = ctrl.en;
                    bus_rdata[BIT_AUTO]       = ctrl.auto_rl;
                    bus_rdata[BIT_PS_L +: 2]  = ctrl.presc;
                end
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R9: an expiry always leaves the flag set, even with a clear write.
    p_expiry_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);
    // R6: a clear write without expiry drops the flag.
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && !expire) |=> !irq);
    // R3: no new interrupt while disabled.
    p_no_irq_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && !irq) |=> !irq);
endmodule

// File: rtl/interval_timer.sv
// Top of the interval timer: register file, prescaler and down-counter.
// Assumes a single clock domain and a synchronous active-low reset.
module interval_timer
    import itmr_pkg::*;
#(
    parameter int MID_SHIFT = 4,
    parameter int HI_SHIFT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] load_val;
    ctrl_t            ctrl;
    logic             load_evt;
    logic             tick;
    logic             expire;

    itmr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_val(cnt_val), .expire(expire), .load_val(load_val),
        .ctrl(ctrl), .load_evt(load_evt), .irq(irq)
    );

    itmr_prescale #(.MID_SHIFT(MID_SHIFT), .HI_SHIFT(HI_SHIFT)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .presc(ctrl.presc),
        .tick(tick)
    );

    itmr_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .load_evt(load_evt),
        .tick(tick), .auto_rl(ctrl.auto_rl), .load_val(load_val),
        .cnt(cnt_val), .expire(expire)
    );
endmodule

// File: tb/interval_timer_tb_top.sv
// Directed bench for the interval timer: one task per scenario.
module interval_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Caller is at a negedge; one write edge is consumed.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        if (n > 0) begin
            repeat (n) @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic quiesce();
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R12 load after reset", d, 0);
        rd(2'd1, d); chk("R12 value after reset", d, 0);
        rd(2'd2, d); chk("R12 ctrl after reset", d, 0);
        chk("R12 irq after reset", irq, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); chk("R1 load upper bits zero", d, 32'h00FF_FFFF);
        wr(2'd2, 32'h4C);
        rd(2'd2, d); chk("R11 ctrl readback", d, 32'h4C);
        wr(2'd2, 32'h33);
        rd(2'd2, d); chk("R11 ctrl unused bits", d, 32'h0);
        wr(2'd1, 32'h123);
        rd(2'd1, d); chk("R11 value write ignored", d, 32'h0);
        rd(2'd3, d); chk("R11 clear reads zero", d, 32'h0);
    endtask

    task automatic t_free_run();
        logic [31:0] d;
        wr(2'd0, 32'h00FF_FFFF);
        wr(2'd2, 32'hC0);
        wait_cyc(10);
        rd(2'd1, d); chk("R2 value after 10 ticks", d, 32'h00FF_FFF5);
        chk("R2 derived up-count", 32'h00FF_FFFF - d, 10);
        quiesce();
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        wr(2'd0, 5);
        wr(2'd2, 32'h80);
        wait_cyc(4);
        rd(2'd1, d); chk("R4 value before expiry", d, 1);
        chk("R4 irq before expiry", irq, 0);
        wait_cyc(1);
        chk("R4 irq at expiry", irq, 1);
        wait_cyc(3);
        rd(2'd1, d); chk("R4 parked at zero", d, 0);
        wr(2'd3, 32'hDEAD_BEEF);
        chk("R6 clear drops irq", irq, 0);
        wait_cyc(5);
        chk("R4 no second irq", irq, 0);
        quiesce();
    endtask

    task automatic t_hold();
        logic [31:0] d;
        wr(2'd0, 5);
        wr(2'd2, 32'h80);
        wait_cyc(3);
        wr(2'd2, 32'h00);
        wait_cyc(10);
        rd(2'd1, d); chk("R3 count held while off", d, 1);
        chk("R3 no irq while off", irq, 0);
        quiesce();
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        wr(2'd0, 4);
        wr(2'd2, 32'hC0);
        wait_cyc(4);
        chk("R5 first periodic irq", irq, 1);
        rd(2'd1, d); chk("R5 reloaded value", d, 4);
        wr(2'd3, 0);
        chk("R6 clear in periodic", irq, 0);
        wait_cyc(3);
        chk("R12 interval 4 second irq", irq, 1);
        rd(2'd1, d); chk("R5 reloaded again", d, 4);
        quiesce();
    endtask

    task automatic t_clear_race();
        wr(2'd0, 4);
        wr(2'd2, 32'hC0);
        wait_cyc(4);
        wr(2'd3, 0);
        wait_cyc(2);
        chk("R9 irq low before race", irq, 0);
        wr(2'd3, 0);
        chk("R9 expiry beats clear", irq, 1);
        quiesce();
    endtask

    task automatic t_no_reload();
        logic [31:0] d;
        wr(2'd0, 50);
        wr(2'd2, 32'h80);
        wait_cyc(5);
        wr(2'd0, 7);
        wr(2'd2, 32'h80);
        rd(2'd1, d); chk("R8 no reload on repeat enable", d, 43);
        quiesce();
    endtask

    task automatic t_div16();
        logic [31:0] d;
        wr(2'd0, 4);
        wr(2'd2, 32'h84);
        wait_cyc(15);
        rd(2'd1, d); chk("R7 div16 before first tick", d, 4);
        wait_cyc(1);
        rd(2'd1, d); chk("R7 div16 first tick", d, 3);
        wait_cyc(47);
        chk("R7 div16 irq not yet", irq, 0);
        wait_cyc(1);
        chk("R7 div16 irq at 64 clocks", irq, 1);
        quiesce();
    endtask

    task automatic t_div256_rsvd();
        wr(2'd0, 2);
        wr(2'd2, 32'h88);
        wait_cyc(511);
        chk("R7 div256 irq not yet", irq, 0);
        wait_cyc(1);
        chk("R7 div256 irq at 512 clocks", irq, 1);
        quiesce();
        wr(2'd0, 3);
        wr(2'd2, 32'h8C);
        wait_cyc(2);
        chk("R7 reserved code not yet", irq, 0);
        wait_cyc(1);
        chk("R7 reserved code acts as div1", irq, 1);
        quiesce();
    endtask

    task automatic t_pre_restart();
        logic [31:0] d;
        wr(2'd0, 10);
        wr(2'd2, 32'h84);
        wait_cyc(20);
        wr(2'd2, 32'h00);
        wr(2'd2, 32'h84);
        wait_cyc(15);
        rd(2'd1, d); chk("R10 no early tick after restart", d, 10);
        wait_cyc(1);
        rd(2'd1, d); chk("R10 tick one period after restart", d, 9);
        quiesce();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_free_run();
        t_oneshot();
        t_hold();
        t_periodic();
        t_clear_race();
        t_no_reload();
        t_div16();
        t_div256_rsvd();
        t_pre_restart();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule